// File: doc/BRIEF.md
# PCI Configuration Cycle Requester

This block turns a single configuration-space read or write request into an indirect transaction on a downstream access unit. A request names the target bus, device slot, function, register offset (0 to 255), an access size of 1, 2 or 4 bytes, and write data. From these the block forms either a local-bus (Type 0) or forwarded (Type 1) configuration address, the active-low byte lane enables and the lane-shifted write data. It then drives an issue handshake and, for reads, one or more data-fetch handshakes.

When the transfer is done it looks at the downstream abort flag. A raised flag is cleared and reported as a missing device. Otherwise the read data is right-aligned to the addressed byte and masked to the access size. Sizes the bus cannot express are refused before any handshake takes place. For access units that need it, a per-request repeat mode replays the issue and fetch steps several times and keeps only the final fetched word.

Top module: `pcfg_requester`

## Requirements
- R1: When req_bus is 0, iss_addr has bit (32 - req_dev) set, with no such bit for device 0. It carries req_func in bits [10:8] and req_off[7:2] in bits [7:2]. All other bits are zero.
- R2: When req_bus is nonzero, iss_addr = {8'h00, bus, dev[4:0], func[2:0], off[7:2], 2'b01}.
- R3: With lane n = req_off[1:0], iss_be_n bit i is 0 (enabled) only for lane n when the size is 1, for lanes n and n+1 when the size is 2, and for all four lanes when the size is 4.
- R4: A size other than 1, 2 or 4, or size 2 with n = 3, returns status 2 (bad register) and rsp_rdata all ones, with no issue or fetch handshake.
- R5: A write issues iss_cmd 4'hB with iss_wdata = req_wdata << 8n in exactly one issue handshake and no fetch.
- R6: A read issues iss_cmd 4'hA, then fetches once. rsp_rdata is the fetched word shifted right by 8n and masked to 8, 16 or 32 bits.
- R7: With req_rep high at acceptance, a read performs 8 issue handshakes, each followed by 2 fetches, and the result comes from the 16th fetched word. A write is unaffected.
- R8: If abort_flag is high after the last handshake, abort_clr pulses for one cycle, the status is 1 (device not found) and rsp_rdata is all ones.
- R9: A request is accepted when req_valid is high and busy is low. busy is high from the cycle after acceptance through the response cycle, rsp_valid lasts one cycle, and req_valid while busy is ignored.
- R10: A completed transfer without abort returns status 0. rsp_rdata is all ones for writes.
- R11: While iss_valid is high and iss_ready is low, iss_valid, iss_addr, iss_be_n and iss_wdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rep | input | 1 | Repeat (errata) mode for this request |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device slot |
| req_func | input | 3 | Target function |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| iss_valid | output | 1 | Issue phase request |
| iss_ready | input | 1 | Issue phase accepted |
| iss_addr | output | 32 | Configuration address |
| iss_cmd | output | 4 | Command code |
| iss_be_n | output | 4 | Active-low byte enables |
| iss_wdata | output | 32 | Lane-shifted write data |
| fet_valid | output | 1 | Data fetch request |
| fet_ready | input | 1 | Fetch accepted, fet_data valid |
| fet_data | input | 32 | Fetched read word |
| abort_flag | input | 1 | Sticky master-abort indication |
| abort_clr | output | 1 | Clears the abort indication |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 0 ok, 1 device not found, 2 bad register |
| rsp_rdata | output | 32 | Aligned read data |

## Verification
The bench builds the block with its defaults: 8 repetitions of 2 fetches, 32-bit data and 8-bit offsets. These values put the full 16-fetch repeat sequence within reach, so a result taken from any fetch other than the last is visible in the returned byte. All four byte lanes and both address formats are reachable as well. The bench's responder accepts handshakes only on alternate cycles, so every issue and fetch meets a stall.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_NODEV  = 2'd1,
    ST_BADREG = 2'd2
  } pcfg_status_e;

  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;
endpackage

// File: rtl/pcfg_addr_fmt.sv
module pcfg_addr_fmt #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int OFF_W = 8,
  parameter int DW    = 32
) (
  input  logic [BUS_W-1:0]          bus,
  input  logic [DEV_W-1:0]          dev,
  input  logic [FN_W-1:0]           fn,
  input  logic [OFF_W-1:0]          off,
  input  logic [2:0]                size,
  input  logic [DW-1:0]             wdata,
  output logic [31:0]               addr,
  output logic [DW/8-1:0]           be_n,
  output logic [$clog2(DW/8)-1:0]   lane,
  output logic                      size_ok,
  output logic [DW-1:0]             wdata_sh
);
  localparam int LANES  = DW / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [2:0] SZ_FULL = 3'(LANES);

  logic        size_half;
  logic        size_full;
  logic [32:0] sel_vec;
  logic [31:0] off_dw;
  logic [31:0] addr_t0;
  logic [31:0] addr_t1;

  assign lane      = off[LANE_W-1:0];
  assign size_half = (size == 3'd2);
  assign size_full = (size == SZ_FULL);
  assign size_ok   = (size == 3'd1) || size_full ||
                     (size_half && (lane != LANE_W'(LANES - 1)));

  // one-hot slot select; slot 0 shifts out of the word
  assign sel_vec = 33'd1 << (6'd32 - 6'(dev));
  assign off_dw  = 32'(off) & ~32'd3;
  assign addr_t0 = sel_vec[31:0] | (32'(fn) << 8) | off_dw;
  assign addr_t1 = (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) |
                   off_dw | 32'd1;
  assign addr    = (bus == '0) ? addr_t0 : addr_t1;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_be
      localparam logic [LANE_W:0] IDX = (LANE_W + 1)'(i);
      assign be_n[i] = ~(size_full ||
                         ({1'b0, lane} == IDX) ||
                         (size_half && (({1'b0, lane} + 1'b1) == IDX)));
    end
  endgenerate

  assign wdata_sh = wdata << {lane, 3'b000};
endmodule

// File: rtl/pcfg_rd_align.sv
module pcfg_rd_align #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]             raw,
  input  logic [$clog2(DW/8)-1:0]   lane,
  input  logic [2:0]                size,
  output logic [DW-1:0]             data
);
  localparam int LANES = DW / 8;
  localparam logic [2:0] SZ_FULL = 3'(LANES);

  logic [DW-1:0] shifted;
  assign shifted = raw >> {lane, 3'b000};

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_mask
      localparam bit IN_HALF = (i < 2);
      localparam bit IN_BYTE = (i == 0);
      logic keep;
      assign keep = (size == SZ_FULL) || (size == 3'd2 && IN_HALF) || IN_BYTE;
      assign data[8*i +: 8] = keep ? shifted[8*i +: 8] : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
  import pcfg_pkg::*;
#(
  parameter int DW            = 32,
  parameter int REP_COUNT     = 8,
  parameter int FETCH_PER_REP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic          start_rep,
  input  logic          size_ok,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic          fet_valid,
  input  logic          fet_ready,
  input  logic [DW-1:0] fet_data,
  input  logic          abort_flag,
  output logic          abort_clr,
  output logic          busy,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic          wr_q,
  output logic [DW-1:0] raw_q
);
  localparam int REP_W = $clog2(REP_COUNT + 1);
  localparam int FET_W = $clog2(FETCH_PER_REP + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_ISSUE, S_FETCH, S_CHECK, S_RESP
  } seq_state_e;

  seq_state_e   state_q, state_d;
  pcfg_status_e status_q, status_d;
  logic         wr_d, rep_mode_q, rep_mode_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic [FET_W-1:0] fet_q, fet_d;
  logic         raw_en;
  logic         last_fetch, last_rep;

  assign last_fetch = !rep_mode_q || (fet_q == FET_W'(FETCH_PER_REP - 1));
  assign last_rep   = !rep_mode_q || (rep_q == REP_W'(REP_COUNT - 1));

  always_comb begin
    state_d    = state_q;
    status_d   = status_q;
    wr_d       = wr_q;
    rep_mode_d = rep_mode_q;
    rep_d      = rep_q;
    fet_d      = fet_q;
    raw_en     = 1'b0;
    iss_valid  = 1'b0;
    fet_valid  = 1'b0;
    abort_clr  = 1'b0;
    rsp_valid  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          wr_d       = start_wr;
          rep_mode_d = start_rep;
          rep_d      = '0;
          fet_d      = '0;
          state_d    = S_DECODE;
        end
      end
      S_DECODE: begin
        if (size_ok) begin
          state_d = S_ISSUE;
        end else begin
          status_d = ST_BADREG;
          state_d  = S_RESP;
        end
      end
      S_ISSUE: begin
        iss_valid = 1'b1;
        if (iss_ready) begin
          fet_d   = '0;
          state_d = wr_q ? S_CHECK : S_FETCH;
        end
      end
      S_FETCH: begin
        fet_valid = 1'b1;
        if (fet_ready) begin
          raw_en = 1'b1;
          if (!last_fetch) begin
            fet_d = fet_q + 1'b1;
          end else if (!last_rep) begin
            rep_d   = rep_q + 1'b1;
            state_d = S_ISSUE;
          end else begin
            state_d = S_CHECK;
          end
        end
      end
      S_CHECK: begin
        if (abort_flag) begin
          abort_clr = 1'b1;
          status_d  = ST_NODEV;
        end else begin
          status_d  = ST_OK;
        end
        state_d = S_RESP;
      end
      S_RESP: begin
        rsp_valid = 1'b1;
        state_d   = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      status_q   <= ST_OK;
      wr_q       <= 1'b0;
      rep_mode_q <= 1'b0;
      rep_q      <= '0;
      fet_q      <= '0;
    end else begin
      state_q    <= state_d;
      status_q   <= status_d;
      wr_q       <= wr_d;
      rep_mode_q <= rep_mode_d;
      rep_q      <= rep_d;
      fet_q      <= fet_d;
    end
  end

  always_ff @(posedge clk) begin
    if (raw_en) begin
      raw_q <= fet_data;
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign rsp_status = status_q;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9

  AST_ABORT_NODEV: assert property (@(posedge clk) disable iff (!rst_n)
    abort_clr |=> (rsp_valid && rsp_status == ST_NODEV)); // R8

  AST_WR_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_valid && $past(iss_valid && iss_ready)) |-> !wr_q); // R5
endmodule

// File: rtl/pcfg_requester.sv
module pcfg_requester
  import pcfg_pkg::*;
#(
  parameter int BUS_W         = 8,
  parameter int DEV_W         = 5,
  parameter int FN_W          = 3,
  parameter int OFF_W         = 8,
  parameter int DW            = 32,
  parameter int REP_COUNT     = 8,
  parameter int FETCH_PER_REP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_rep,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_func,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [2:0]        req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [31:0]       iss_addr,
  output logic [3:0]        iss_cmd,
  output logic [DW/8-1:0]   iss_be_n,
  output logic [DW-1:0]     iss_wdata,
  output logic              fet_valid,
  input  logic              fet_ready,
  input  logic [DW-1:0]     fet_data,
  input  logic              abort_flag,
  output logic              abort_clr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DW-1:0]     rsp_rdata
);
  localparam int LANE_W = $clog2(DW / 8);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // request capture
  logic              accept;
  logic [BUS_W-1:0]  q_bus;
  logic [DEV_W-1:0]  q_dev;
  logic [FN_W-1:0]   q_fn;
  logic [OFF_W-1:0]  q_off;
  logic [2:0]        q_size;
  logic [DW-1:0]     q_wdata;

  assign accept = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (accept) begin
      q_bus   <= req_bus;
      q_dev   <= req_dev;
      q_fn    <= req_func;
      q_off   <= req_off;
      q_size  <= req_size;
      q_wdata <= req_wdata;
    end
  end

  logic [LANE_W-1:0] lane;
  logic              size_ok;
  logic              wr_q;
  logic [DW-1:0]     raw_q;
  logic [DW-1:0]     rd_aligned;

  pcfg_addr_fmt #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W), .DW(DW)
  ) u_addr_fmt (
    .bus      (q_bus),
    .dev      (q_dev),
    .fn       (q_fn),
    .off      (q_off),
    .size     (q_size),
    .wdata    (q_wdata),
    .addr     (iss_addr),
    .be_n     (iss_be_n),
    .lane     (lane),
    .size_ok  (size_ok),
    .wdata_sh (iss_wdata)
  );

  pcfg_seq #(
    .DW(DW), .REP_COUNT(REP_COUNT), .FETCH_PER_REP(FETCH_PER_REP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (accept),
    .start_wr   (req_write),
    .start_rep  (req_rep),
    .size_ok    (size_ok),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .fet_valid  (fet_valid),
    .fet_ready  (fet_ready),
    .fet_data   (fet_data),
    .abort_flag (abort_flag),
    .abort_clr  (abort_clr),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .wr_q       (wr_q),
    .raw_q      (raw_q)
  );

  pcfg_rd_align #(.DW(DW)) u_rd_align (
    .raw  (raw_q),
    .lane (lane),
    .size (q_size),
    .data (rd_aligned)
  );

  assign iss_cmd   = wr_q ? CMD_CFG_WR : CMD_CFG_RD;
  assign rsp_rdata = (rsp_status == ST_OK && !wr_q) ? rd_aligned : '1;

  AST_ISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (iss_valid && !iss_ready) |=>
      (iss_valid && $stable(iss_addr) && $stable(iss_be_n) && $stable(iss_wdata))); // R11

  AST_ISS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n_int)
    iss_valid |-> size_ok); // R4

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n_int)
    iss_valid |-> ($countones(~iss_be_n) == 32'(q_size))); // R3

  AST_T1_TAG: assert property (@(posedge clk) disable iff (!rst_n_int)
    (iss_valid && q_bus != '0) |-> iss_addr[0]); // R2

  AST_BUSY_RSP: assert property (@(posedge clk) disable iff (!rst_n_int)
    rsp_valid |-> busy); // R9
endmodule

// File: tb/pcfg_requester_bench.sv
`timescale 1ns/1ps
module pcfg_requester_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_rep = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_off = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        busy, iss_valid, iss_ready, fet_valid, fet_ready;
  logic [31:0] iss_addr, iss_wdata, fet_data, rsp_rdata;
  logic [3:0]  iss_cmd, iss_be_n;
  logic        abort_flag = 1'b0;
  logic        abort_clr, rsp_valid;
  logic [1:0]  rsp_status;

  always #4 clk = ~clk;

  pcfg_requester u_pcfg_requester (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_rep(req_rep), .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata), .busy(busy),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr),
    .iss_cmd(iss_cmd), .iss_be_n(iss_be_n), .iss_wdata(iss_wdata),
    .fet_valid(fet_valid), .fet_ready(fet_ready), .fet_data(fet_data),
    .abort_flag(abort_flag), .abort_clr(abort_clr), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
  );

  // downstream responder: accepts on alternate cycles
  logic        gate = 1'b0;
  logic        clr_stats = 1'b0;
  logic        abort_arm = 1'b0;
  logic [31:0] rd_base = '0;
  int          n_iss = 0, n_fet = 0, n_clr = 0, n_rsp = 0;
  logic [31:0] cap_addr = '0, cap_wdata = '0;
  logic [3:0]  cap_be = '0, cap_cmd = '0;

  always @(negedge clk) gate <= ~gate;
  assign iss_ready = iss_valid & gate;
  assign fet_ready = fet_valid & gate;
  assign fet_data  = rd_base + 32'(n_fet);

  always @(posedge clk) begin
    if (clr_stats) begin
      n_iss <= 0; n_fet <= 0; n_clr <= 0; n_rsp <= 0;
    end else begin
      if (iss_valid && iss_ready) begin
        n_iss     <= n_iss + 1;
        cap_addr  <= iss_addr;
        cap_be    <= iss_be_n;
        cap_cmd   <= iss_cmd;
        cap_wdata <= iss_wdata;
        if (abort_arm) abort_flag <= 1'b1;
      end
      if (fet_valid && fet_ready) n_fet <= n_fet + 1;
      if (abort_clr) begin
        n_clr      <= n_clr + 1;
        abort_flag <= 1'b0;
      end
      if (rsp_valid) n_rsp <= n_rsp + 1;
    end
  end

  int total = 0, bad = 0;
  int cycles = 0;
  logic [1:0]  r_status;
  logic [31:0] r_rdata;
  logic        r_busy;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic run_req(input logic wr, input logic rep, input logic [7:0] bus,
                         input logic [4:0] dev, input logic [2:0] fn,
                         input logic [7:0] off, input logic [2:0] size,
                         input logic [31:0] wd);
    @(negedge clk) clr_stats = 1'b1;
    @(negedge clk) clr_stats = 1'b0;
    req_write = wr; req_rep = rep; req_bus = bus; req_dev = dev;
    req_func = fn; req_off = off; req_size = size; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
    r_busy = busy;
    for (int g = 0; g < 2000 && !rsp_valid; g++) @(negedge clk);
    r_status = rsp_status;
    r_rdata  = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", 32'(busy), 0);
    chk("R9 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R11 reset iss_valid", 32'(iss_valid), 0);
    chk("R8 reset abort_clr", 32'(abort_clr), 0);
  endtask

  task automatic t_type0_read();
    rd_base = 32'hA1B2C3D4;
    run_req(1'b0, 1'b0, 8'h00, 5'd5, 3'd3, 8'h12, 3'd2, 32'h0);
    chk("R1 type0 addr", cap_addr, 32'h0800_0310);
    chk("R3 be half lane2", 32'(cap_be), 32'h3);
    chk("R6 read cmd", 32'(cap_cmd), 32'hA);
    chk("R6 read issues", n_iss, 1);
    chk("R6 read fetches", n_fet, 1);
    chk("R6 half rdata", r_rdata, 32'h0000A1B2);
    chk("R10 read status", 32'(r_status), 0);
    chk("R9 busy after accept", 32'(r_busy), 1);
  endtask

  task automatic t_type1_write();
    run_req(1'b1, 1'b0, 8'h3C, 5'h11, 3'd6, 8'h47, 3'd1, 32'h0000005A);
    chk("R2 type1 addr", cap_addr, 32'h003C8E45);
    chk("R3 be byte lane3", 32'(cap_be), 32'h7);
    chk("R5 write cmd", 32'(cap_cmd), 32'hB);
    chk("R5 write data lanes", cap_wdata, 32'h5A000000);
    chk("R5 write issues", n_iss, 1);
    chk("R5 write fetches", n_fet, 0);
    chk("R10 write status", 32'(r_status), 0);
    chk("R10 write rdata", r_rdata, 32'hFFFFFFFF);
  endtask

  task automatic t_full_read();
    rd_base = 32'h13579BDF;
    run_req(1'b0, 1'b0, 8'h00, 5'd1, 3'd0, 8'h40, 3'd4, 32'h0);
    chk("R1 slot1 addr", cap_addr, 32'h8000_0040);
    chk("R3 be full", 32'(cap_be), 32'h0);
    chk("R6 full rdata", r_rdata, 32'h13579BDF);
  endtask

  task automatic t_slot0();
    rd_base = 32'h00000077;
    run_req(1'b0, 1'b0, 8'h00, 5'd0, 3'd1, 8'h08, 3'd4, 32'h0);
    chk("R1 slot0 no select", cap_addr, 32'h0000_0108);
  endtask

  task automatic t_half_write();
    run_req(1'b1, 1'b0, 8'h01, 5'd0, 3'd0, 8'h05, 3'd2, 32'h0000BEEF);
    chk("R2 bus1 addr", cap_addr, 32'h0001_0005);
    chk("R3 be half lane1", 32'(cap_be), 32'h9);
    chk("R5 half write data", cap_wdata, 32'h00BEEF00);
  endtask

  task automatic t_bad_size();
    run_req(1'b0, 1'b0, 8'h00, 5'd3, 3'd0, 8'h00, 3'd3, 32'h0);
    chk("R4 size3 status", 32'(r_status), 2);
    chk("R4 size3 rdata", r_rdata, 32'hFFFFFFFF);
    chk("R4 size3 no issue", n_iss, 0);
    chk("R4 size3 no fetch", n_fet, 0);
    run_req(1'b1, 1'b0, 8'h00, 5'd3, 3'd0, 8'h0B, 3'd2, 32'h1234);
    chk("R4 half lane3 status", 32'(r_status), 2);
    chk("R4 half lane3 no issue", n_iss, 0);
  endtask

  task automatic t_repeat();
    rd_base = 32'h11223340;
    run_req(1'b0, 1'b1, 8'h02, 5'd0, 3'd0, 8'h00, 3'd1, 32'h0);
    chk("R7 repeat issues", n_iss, 8);
    chk("R7 repeat fetches", n_fet, 16);
    chk("R7 repeat last value", r_rdata, 32'h0000004F);
    run_req(1'b1, 1'b1, 8'h02, 5'd0, 3'd0, 8'h00, 3'd4, 32'hCAFEF00D);
    chk("R7 repeat write issues", n_iss, 1);
    chk("R7 repeat write fetches", n_fet, 0);
  endtask

  task automatic t_abort();
    rd_base = 32'h0;
    abort_arm = 1'b1;
    run_req(1'b0, 1'b0, 8'h00, 5'd2, 3'd0, 8'h00, 3'd4, 32'h0);
    abort_arm = 1'b0;
    chk("R8 abort status", 32'(r_status), 1);
    chk("R8 abort rdata", r_rdata, 32'hFFFFFFFF);
    chk("R8 abort clear pulses", n_clr, 1);
    chk("R8 abort flag cleared", 32'(abort_flag), 0);
    rd_base = 32'h00C0FFEE;
    run_req(1'b0, 1'b0, 8'h00, 5'd2, 3'd0, 8'h00, 3'd4, 32'h0);
    chk("R8 next read ok", 32'(r_status), 0);
    chk("R8 no spurious clear", n_clr, 0);
  endtask

  task automatic t_ignore_busy();
    rd_base = 32'h55AA66BB;
    @(negedge clk) clr_stats = 1'b1;
    @(negedge clk) clr_stats = 1'b0;
    req_write = 1'b0; req_rep = 1'b0; req_bus = 8'h00; req_dev = 5'd4;
    req_func = 3'd0; req_off = 8'h00; req_size = 3'd4; req_valid = 1'b1;
    @(negedge clk);
    chk("R9 busy held", 32'(busy), 1);
    req_write = 1'b1; req_bus = 8'h09; req_wdata = 32'hDEAD0000;
    @(negedge clk);
    @(negedge clk) req_valid = 1'b0;
    for (int g = 0; g < 2000 && !rsp_valid; g++) @(negedge clk);
    r_rdata = rsp_rdata;
    for (int k = 0; k < 6; k++) @(negedge clk);
    chk("R9 ignored one response", n_rsp, 1);
    chk("R9 ignored one issue", n_iss, 1);
    chk("R9 ignored kept read", 32'(cap_cmd), 32'hA);
    chk("R9 ignored kept data", r_rdata, 32'h55AA66BB);
  endtask

  initial begin
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_type0_read();
    t_type1_write();
    t_full_read();
    t_slot0();
    t_half_write();
    t_bad_size();
    t_repeat();
    t_abort();
    t_ignore_busy();
    finish_run();
  end
endmodule